// File: doc/BRIEF.md
# Line Event and Double-Buffer Sequencer

This block sits beside the write path of a capture pipe and keeps two small pieces of frame bookkeeping. It counts the capture lines that finish inside a frame and raises a one-cycle line event each time a programmable power-of-two group of lines is complete. The group size is given as a 3-bit exponent, so one code covers periods from 1 to 128 lines. The exponent is sampled when a frame opens, and the count restarts at the top of every frame.

It also picks the memory base address that the current frame is written to. With ping-pong buffering off, every frame goes to the first programmed base. With it on, the selection flips at each frame end, so the next frame opens on the other base. The first frame after enabling always uses the first base. Turning ping-pong buffering off sends the selection back to the first base.

Top module: `line_evt_dbuf_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `line_evt` and `buf_sel` to 0 and loads `cur_addr` with `base_a`.
- R2: With latched exponent code n (0 to 7), `line_evt` is high for the cycle after the `line_end` that completes every 2^n-th line of a frame. Each line is counted once, at its `line_end` pulse.
- R3: `line_evt` is a single-cycle pulse for each completed group. The line count wraps to zero after every event, so the next event needs another full group of 2^n lines.
- R4: A `frm_start` pulse clears any partial line count, so the lines of a frame are counted from that frame's start.
- R5: `mult_code` is sampled only on `frm_start`. A change in the middle of a frame has no effect on event spacing until the next frame starts.
- R6: A `line_end` is ignored if it arrives outside a frame (after `frm_end` and before the next `frm_start`) or in the same cycle as `frm_start`. A `line_end` in the same cycle as `frm_end` is still counted.
- R7: While `dbuf_en` is 0, `buf_sel` is 0 (first buffer) and `cur_addr` follows `base_a`.
- R8: While `dbuf_en` is 1, `buf_sel` inverts on each `frm_end` and holds otherwise. Because the selector starts from 0, the first frame uses `base_a`. `buf_sel` = 1 selects `base_b`.
- R9: A `dbuf_en` of 0 at a clock edge returns `buf_sel` to 0 at that edge, even from the second buffer.
- R10: `buf_sel` and `cur_addr` are registered. Both change together one cycle after the input that causes the change, and `cur_addr` is the base chosen by the new `buf_sel`, as the bases were at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | One-cycle pulse marking the start of a frame |
| frm_end | input | 1 | One-cycle pulse marking the end of a frame |
| line_end | input | 1 | One-cycle pulse when a captured line completes |
| mult_code | input | 3 | Event period exponent; the period is 2^code lines |
| dbuf_en | input | 1 | Ping-pong buffering enable |
| base_a | input | ADDR_W | First programmed base address |
| base_b | input | ADDR_W | Second programmed base address |
| line_evt | output | 1 | One-cycle line event pulse |
| cur_addr | output | ADDR_W | Base address for the current frame |
| buf_sel | output | 1 | Buffer in use: 0 = first, 1 = second |

## Verification
If the line counter or the latched exponent holds a wrong value, the fault first shows as a `line_evt` pulse that comes early, comes late or is missing. It appears at the first group boundary after the fault and stays visible until the next frame start clears the count. If the buffer selector is wrong, `buf_sel` and `cur_addr` point at the wrong base for the whole of the next frame. A missed toggle or an unforced reset of the selector therefore shows within one cycle of the frame end or enable change that should have moved it. Because of this, the scoreboard compares all three outputs on every cycle, and the stimulus places the frame edges, enable changes and line pulses so that each of these faults reaches a compared cycle.

// File: rtl/lev_pkg.sv
package lev_pkg;

  typedef enum logic {
    BUF_FIRST  = 1'b0,
    BUF_SECOND = 1'b1
  } buf_id_e;

  // Number of counter bits needed for the largest exponent of a code width
  function automatic int cnt_bits(input int code_w);
    int max_exp;
    max_exp = (1 << code_w) - 1;
    return (max_exp > 0) ? max_exp : 1;
  endfunction

endpackage

// File: rtl/lev_frame_track.sv
module lev_frame_track #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic [CODE_W-1:0] mult_code,
  output logic              in_frame,
  output logic [CODE_W-1:0] code_q
);

  // Start takes priority over end when both arrive together
  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      code_q   <= '0;
    end else if (frm_start) begin
      in_frame <= 1'b1;
      code_q   <= mult_code;
    end else if (frm_end) begin
      in_frame <= 1'b0;
    end
  end

endmodule

// File: rtl/lev_line_counter.sv
module lev_line_counter #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = lev_pkg::cnt_bits(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              line_end,
  input  logic              in_frame,
  input  logic [CODE_W-1:0] code_q,
  output logic              line_evt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;
  logic             count_en;

  // Terminal index is 2^code - 1: low 'code' bits set
  always_comb begin
    last_idx = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(code_q)) last_idx[i] = 1'b1;
    end
  end

  assign count_en = line_end && in_frame && !frm_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      line_evt <= 1'b0;
    end else begin
      line_evt <= 1'b0;
      if (frm_start) begin
        cnt_q <= '0;
      end else if (count_en) begin
        if (cnt_q == last_idx) begin
          cnt_q    <= '0;
          line_evt <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lev_buf_select.sv
module lev_buf_select #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_end,
  input  logic              dbuf_en,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  output logic              buf_sel,
  output logic [ADDR_W-1:0] cur_addr
);
  import lev_pkg::*;

  buf_id_e sel_q;
  buf_id_e sel_d;

  always_comb begin
    if (!dbuf_en)     sel_d = BUF_FIRST;
    else if (frm_end) sel_d = (sel_q == BUF_FIRST) ? BUF_SECOND : BUF_FIRST;
    else              sel_d = sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= BUF_FIRST;
      cur_addr <= base_a;
    end else begin
      sel_q    <= sel_d;
      cur_addr <= (sel_d == BUF_SECOND) ? base_b : base_a;
    end
  end

  assign buf_sel = sel_q;

endmodule

// File: rtl/line_evt_dbuf_seq.sv
module line_evt_dbuf_seq #(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic              line_end,
  input  logic [CODE_W-1:0] mult_code,
  input  logic              dbuf_en,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  output logic              line_evt,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              buf_sel
);

  localparam int CNT_W = lev_pkg::cnt_bits(CODE_W);

  logic              in_frame_w;
  logic [CODE_W-1:0] code_w;

  lev_frame_track #(.CODE_W(CODE_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .frm_start (frm_start),
    .frm_end   (frm_end),
    .mult_code (mult_code),
    .in_frame  (in_frame_w),
    .code_q    (code_w)
  );

  lev_line_counter #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_lines (
    .clk       (clk),
    .rst       (rst),
    .frm_start (frm_start),
    .line_end  (line_end),
    .in_frame  (in_frame_w),
    .code_q    (code_w),
    .line_evt  (line_evt)
  );

  lev_buf_select #(.ADDR_W(ADDR_W)) u_bufs (
    .clk      (clk),
    .rst      (rst),
    .frm_end  (frm_end),
    .dbuf_en  (dbuf_en),
    .base_a   (base_a),
    .base_b   (base_b),
    .buf_sel  (buf_sel),
    .cur_addr (cur_addr)
  );

endmodule

// File: rtl/lev_seq_chk.sv
module lev_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_start,
  input logic              frm_end,
  input logic              line_end,
  input logic              dbuf_en,
  input logic [ADDR_W-1:0] base_a,
  input logic [ADDR_W-1:0] base_b,
  input logic              in_frame,
  input logic              line_evt,
  input logic              buf_sel,
  input logic [ADDR_W-1:0] cur_addr
);

  a_r2_evt_after_line: assert property (@(posedge clk) disable iff (rst)
    line_evt |-> ($past(line_end) && $past(in_frame)));

  a_r6_start_blocks_line: assert property (@(posedge clk) disable iff (rst)
    line_evt |-> !$past(frm_start));

  a_r7_single_buffer: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dbuf_en)) |-> (buf_sel == 1'b0));

  a_r8_hold_sel: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dbuf_en) && !$past(frm_end)) |-> $stable(buf_sel));

  a_r8_toggle_sel: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dbuf_en) && $past(frm_end)) |-> (buf_sel != $past(buf_sel)));

  a_r10_addr_match: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cur_addr == (buf_sel ? $past(base_b) : $past(base_a))));

endmodule

bind line_evt_dbuf_seq lev_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frm_start (frm_start),
  .frm_end   (frm_end),
  .line_end  (line_end),
  .dbuf_en   (dbuf_en),
  .base_a    (base_a),
  .base_b    (base_b),
  .in_frame  (in_frame_w),
  .line_evt  (line_evt),
  .buf_sel   (buf_sel),
  .cur_addr  (cur_addr)
);

// File: tb/sim_line_evt_dbuf_seq.sv
module sim_line_evt_dbuf_seq;
  localparam int ADDR_W = 32;
  localparam int CODE_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_start = 1'b0, frm_end = 1'b0, line_end = 1'b0, dbuf_en = 1'b0;
  logic [CODE_W-1:0] mult_code = '0;
  logic [ADDR_W-1:0] base_a = '0, base_b = '0;
  logic line_evt, buf_sel;
  logic [ADDR_W-1:0] cur_addr;

  always #4 clk = ~clk;

  line_evt_dbuf_seq #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u0 (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_end(frm_end),
    .line_end(line_end), .mult_code(mult_code), .dbuf_en(dbuf_en),
    .base_a(base_a), .base_b(base_b), .line_evt(line_evt),
    .cur_addr(cur_addr), .buf_sel(buf_sel)
  );

  typedef struct {
    logic              evt;
    logic              sel;
    logic [ADDR_W-1:0] addr;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Shadow settings applied at the next drive
  logic              s_rst = 1'b1, s_dbe = 1'b0;
  logic [CODE_W-1:0] s_code = '0;
  logic [ADDR_W-1:0] s_a = 32'h1000_0000, s_b = 32'h2000_0000;

  // Reference model state
  int   m_cnt = 0, m_code = 0;
  bit   m_act = 0, m_sel = 0;

  task automatic drive(input bit fs, input bit fe, input bit le, input string tag);
    exp_t e;
    @(negedge clk);
    rst = s_rst; frm_start = fs; frm_end = fe; line_end = le;
    mult_code = s_code; dbuf_en = s_dbe; base_a = s_a; base_b = s_b;
    e.evt = 1'b0;
    if (s_rst) begin
      m_cnt = 0; m_code = 0; m_act = 0; m_sel = 0;
    end else begin
      if (fs) m_cnt = 0;
      else if (le && m_act) begin
        if (m_cnt == (1 << m_code) - 1) begin e.evt = 1'b1; m_cnt = 0; end
        else m_cnt++;
      end
      if (fs) begin m_act = 1; m_code = int'(s_code); end
      else if (fe) m_act = 0;
      if (!s_dbe) m_sel = 0;
      else if (fe) m_sel = !m_sel;
    end
    e.sel  = m_sel;
    e.addr = m_sel ? s_b : s_a;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, tag);
  endtask

  task automatic line(input string tag);
    drive(0, 0, 1, tag);
    drive(0, 0, 0, tag);
  endtask

  task automatic lines(input int n, input string tag);
    for (int i = 0; i < n; i++) line(tag);
  endtask

  task automatic chk(input string tag, input string what, input logic [ADDR_W-1:0] act,
                     input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: compares outputs after each edge against queued expectations
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(e.tag, "line_evt", {{(ADDR_W-1){1'b0}}, line_evt}, {{(ADDR_W-1){1'b0}}, e.evt});
        chk(e.tag, "buf_sel",  {{(ADDR_W-1){1'b0}}, buf_sel},  {{(ADDR_W-1){1'b0}}, e.sel});
        chk(e.tag, "cur_addr", cur_addr, e.addr);
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    s_rst = 1'b1;
    idle(3, "R1");
    s_rst = 1'b0;
    idle(2, "R1");

    // R2 / R7: single buffer, period of 4 lines
    s_code = 3'd2; s_dbe = 1'b0;
    drive(1, 0, 0, "R2");
    lines(10, "R2");
    drive(0, 1, 0, "R7");
    idle(2, "R7");
    drive(1, 0, 0, "R7");
    lines(3, "R7");
    drive(0, 1, 1, "R7");
    idle(2, "R7");

    // R2 / R3: every code, with extra lines past one group
    for (int c = 0; c < 8; c++) begin
      s_code = 3'(c);
      drive(1, 0, 0, "R2");
      lines((1 << c) + 3, "R3");
      drive(0, 1, 0, "R3");
      idle(1, "R3");
    end
    // back-to-back line pulses with code 0
    s_code = 3'd0;
    drive(1, 0, 0, "R3");
    for (int i = 0; i < 4; i++) drive(0, 0, 1, "R3");
    drive(0, 1, 0, "R3");

    // R4: partial count discarded by new frame start
    s_code = 3'd3;
    drive(1, 0, 0, "R4");
    lines(5, "R4");
    drive(1, 0, 0, "R4");
    lines(9, "R4");
    drive(0, 1, 0, "R4");

    // R5: code change mid-frame has no effect until next start
    s_code = 3'd1;
    drive(1, 0, 0, "R5");
    line("R5");
    s_code = 3'd3;
    lines(5, "R5");
    drive(0, 1, 0, "R5");
    drive(1, 0, 0, "R5");
    lines(8, "R5");
    drive(0, 1, 0, "R5");

    // R6: lines outside frame and with frame start ignored
    s_code = 3'd0;
    lines(3, "R6");
    drive(1, 0, 1, "R6");
    idle(1, "R6");
    line("R6");
    drive(0, 1, 1, "R6");
    idle(1, "R6");

    // R8 / R10: ping-pong over several frames, bases changing
    s_dbe = 1'b1; s_code = 3'd1;
    idle(1, "R8");
    for (int f = 0; f < 5; f++) begin
      drive(1, 0, 0, "R8");
      lines(4, "R8");
      if (f == 2) begin
        s_a = 32'hA5A5_0000; s_b = 32'h5A5A_0000;
        idle(2, "R10");
      end
      drive(0, 1, 0, "R8");
      idle(1, "R10");
    end

    // R9: disabling while on second buffer forces first
    drive(1, 0, 0, "R9");
    drive(0, 1, 0, "R9");
    idle(1, "R9");
    s_dbe = 1'b0;
    idle(2, "R9");
    s_a = 32'h0000_1234;
    idle(2, "R10");
    s_dbe = 1'b1;
    drive(0, 1, 0, "R9");
    drive(0, 0, 0, "R9");
    s_dbe = 1'b0;
    drive(0, 1, 0, "R9");
    idle(3, "R9");

    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    #3;
    done = 1;
    finish_run();
  end

endmodule